// File: doc/BRIEF.md
# PCI Target Address-Phase Decoder

This block watches a PCI bus from the target side. It catches the address phase, which is the first clock on which FRAME# is sampled low. On that clock it decides whether the device claims the transaction. It accepts configuration cycles that are gated by IDSEL and aimed at function 0. It also accepts I/O and memory cycles whose upper 24 address bits fall inside one of two 256-byte windows.

One clock after the address phase the block reports four things: a claim pulse, the targeted space, the transfer direction and the selected byte offset. It also reports whether a configuration access lands on the parameter half of configuration space. The operating-register index is folded so that both 128-byte halves of a window reach the same registers.

The block owns two base registers. The I/O base sits at configuration offset 0x10 and the memory base at offset 0x14. Configuration writes to those offsets load them from the first data clock. Their low byte is fixed.

Top module: `pci_addr_decode`

## Requirements
- R1: After reset, hit_o is 0, bar0_o reads 0x00000001 and bar1_o reads 0x00000000.
- R2: A configuration command is claimed only when idsel_i is 1 in the address phase. Otherwise hit_o stays 0 and neither base register changes.
- R3: A configuration command is claimed only when ad_i[10:8] is 000 and ad_i[1:0] is 00.
- R4: A claimed configuration access reports offset_o = {ad_i[7:2],2'b00}. param_o is 1 for offsets below 0x80 and 0 for offsets 0x80 and above. param_o is always 0 for memory and I/O claims.
- R5: An I/O command is claimed only when ad_i[31:8] equals bar0_o[31:8], comparing every one of these bits. offset_o is then ad_i[7:0].
- R6: A memory command is claimed only when ad_i[31:8] equals bar1_o[31:8]. offset_o is then ad_i[7:0]. A memory command aimed at the I/O window is not claimed.
- R7: reg_idx_o equals offset_o[6:0], so offsets 0xNN and 0xNN+0x80 select the same operating register.
- R8: The claimed commands are 0010 (I/O read), 0011 (I/O write), 0110 (memory read), 0111 (memory write), 1010 (configuration read) and 1011 (configuration write), taken from cbe_ni. Every other command is ignored. write_o equals bit 0 of the command.
- R9: A decision is made only on the first clock where frame_ni is sampled low. The result shows on the outputs after that same edge, and hit_o is a single-cycle pulse even when frame_ni stays low.
- R10: A claimed configuration write to offset 0x10 (I/O base) or 0x14 (memory base) loads bits [31:8] of that register from ad_i on the next clock. Only the byte lanes whose cbe_ni bit is 0 are loaded. Bits [7:0] always read 0x01 for the I/O base and 0x00 for the memory base.
- R11: space_o encodes 00 none, 01 configuration, 10 memory, 11 I/O. It reads 00 whenever hit_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | PCI clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | FRAME#, active low |
| ad_i | input | 32 | Address/data bus |
| cbe_ni | input | 4 | Command / byte enables, byte enables active low |
| idsel_i | input | 1 | Configuration select |
| hit_o | output | 1 | Claim pulse, one clock after the address phase |
| space_o | output | 2 | Targeted space |
| write_o | output | 1 | 1 for a write command |
| offset_o | output | 8 | Selected byte offset |
| param_o | output | 1 | Configuration access to the parameter half |
| reg_idx_o | output | 7 | Folded operating-register index |
| bar0_o | output | 32 | I/O base register read-back |
| bar1_o | output | 32 | Memory base register read-back |

## Verification
The bench aims at the gates a sloppy decoder drops. It sends configuration cycles without IDSEL, with a nonzero function number and with a nonzero type field. A decoder that skipped any of these checks would claim those cycles, and a write to a base offset would also corrupt that base register. It flips the top address bit and bit 8 of the I/O address, which catches a comparator that treats some bits as don't-care. It probes both halves of a window, which exposes a missing fold of bit 7. It also holds FRAME# low over several clocks, which catches a decoder that reclaims every cycle. Partial byte-enable writes and reserved commands show whether a lane mask is ignored or an unlisted command is accepted.

// File: rtl/pci_dec_pkg.sv
package pci_dec_pkg;
  typedef enum logic [1:0] {
    SP_NONE = 2'b00,
    SP_CFG  = 2'b01,
    SP_MEM  = 2'b10,
    SP_IO   = 2'b11
  } space_e;

  typedef enum logic [1:0] {
    K_NONE = 2'b00,
    K_IO   = 2'b01,
    K_MEM  = 2'b10,
    K_CFG  = 2'b11
  } kind_e;

  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;
endpackage

// File: rtl/pci_cmd_decode.sv
module pci_cmd_decode
  import pci_dec_pkg::*;
(
  input  logic [3:0] cmd_i,
  output kind_e      kind_o,
  output logic       wr_o
);
  always_comb begin
    unique case (cmd_i)
      CMD_IO_RD, CMD_IO_WR:   kind_o = K_IO;
      CMD_MEM_RD, CMD_MEM_WR: kind_o = K_MEM;
      CMD_CFG_RD, CMD_CFG_WR: kind_o = K_CFG;
      default:                kind_o = K_NONE;
    endcase
  end
  assign wr_o = cmd_i[0];
endmodule

// File: rtl/pci_window_match.sv
module pci_window_match #(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              match_o
);
  localparam int TAG_W = ADDR_W - WIN_BITS;
  logic [TAG_W-1:0] addr_tag, base_tag;
  assign addr_tag = addr_i[ADDR_W-1:WIN_BITS];
  assign base_tag = base_i[ADDR_W-1:WIN_BITS];
  assign match_o  = (addr_tag == base_tag);
endmodule

// File: rtl/pci_bar_reg.sv
module pci_bar_reg #(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 8,
  parameter bit IS_IO    = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   data_i,
  input  logic [ADDR_W/8-1:0] be_i,
  output logic [ADDR_W-1:0]   bar_o
);
  localparam int NLANE = ADDR_W / 8;
  localparam logic [ADDR_W-1:0] FIXED = ADDR_W'(IS_IO);

  for (genvar b = 0; b < NLANE; b++) begin : g_lane
    if (b * 8 >= WIN_BITS) begin : g_rw
      logic [7:0] lane_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                lane_q <= '0;
        else if (wr_i && be_i[b])   lane_q <= data_i[b*8 +: 8];
      end
      assign bar_o[b*8 +: 8] = lane_q;
    end else begin : g_ro
      assign bar_o[b*8 +: 8] = FIXED[b*8 +: 8];
    end
  end
endmodule

// File: rtl/pci_addr_decode.sv
module pci_addr_decode
  import pci_dec_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WIN_BITS    = 8,
  parameter int CFG_BAR0_DW = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_ni,
  input  logic [ADDR_W-1:0]   ad_i,
  input  logic [3:0]          cbe_ni,
  input  logic                idsel_i,
  output logic                hit_o,
  output logic [1:0]          space_o,
  output logic                write_o,
  output logic [WIN_BITS-1:0] offset_o,
  output logic                param_o,
  output logic [WIN_BITS-2:0] reg_idx_o,
  output logic [ADDR_W-1:0]   bar0_o,
  output logic [ADDR_W-1:0]   bar1_o
);
  localparam int NLANE = ADDR_W / 8;
  localparam int NBAR  = 2;
  localparam logic [5:0] DW_BAR0 = 6'(CFG_BAR0_DW);
  localparam logic [5:0] DW_BAR1 = 6'(CFG_BAR0_DW + 1);

  logic frame_q;
  logic addr_ph;
  kind_e kind;
  logic cmd_wr;
  logic io_match, mem_match;
  logic claim;
  space_e sp_d;
  logic [WIN_BITS-1:0] off_d;
  logic bar_sel_hit, bar_sel_d;
  logic wr_pend_q, wr_sel_q;
  logic [ADDR_W-1:0] bar_q [NBAR];

  logic hit_q, wr_q, param_q;
  space_e sp_q;
  logic [WIN_BITS-1:0] off_q;

  // address phase = first clock FRAME# seen low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frame_q <= 1'b1;
    else         frame_q <= frame_ni;
  end
  assign addr_ph = !frame_ni && frame_q;

  pci_cmd_decode u_cmd (
    .cmd_i  (cbe_ni),
    .kind_o (kind),
    .wr_o   (cmd_wr)
  );

  pci_window_match #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_io_win (
    .addr_i  (ad_i),
    .base_i  (bar_q[0]),
    .match_o (io_match)
  );

  pci_window_match #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_mem_win (
    .addr_i  (ad_i),
    .base_i  (bar_q[1]),
    .match_o (mem_match)
  );

  always_comb begin
    claim = 1'b0;
    sp_d  = SP_NONE;
    off_d = ad_i[WIN_BITS-1:0];
    unique case (kind)
      K_CFG: begin
        claim = idsel_i && (ad_i[10:8] == 3'b000) && (ad_i[1:0] == 2'b00);
        sp_d  = SP_CFG;
        off_d = {ad_i[WIN_BITS-1:2], 2'b00};
      end
      K_IO: begin
        claim = io_match;
        sp_d  = SP_IO;
      end
      K_MEM: begin
        claim = mem_match;
        sp_d  = SP_MEM;
      end
      default: claim = 1'b0;
    endcase
  end

  assign bar_sel_hit = (ad_i[7:2] == DW_BAR0) || (ad_i[7:2] == DW_BAR1);
  assign bar_sel_d   = (ad_i[7:2] == DW_BAR1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q   <= 1'b0;
      sp_q    <= SP_NONE;
      wr_q    <= 1'b0;
      off_q   <= '0;
      param_q <= 1'b0;
    end else if (addr_ph && claim) begin
      hit_q   <= 1'b1;
      sp_q    <= sp_d;
      wr_q    <= cmd_wr;
      off_q   <= off_d;
      param_q <= (kind == K_CFG) && !off_d[WIN_BITS-1];
    end else begin
      hit_q   <= 1'b0;
      sp_q    <= SP_NONE;
      wr_q    <= 1'b0;
      off_q   <= '0;
      param_q <= 1'b0;
    end
  end

  // base register load is taken from the first data clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_pend_q <= 1'b0;
      wr_sel_q  <= 1'b0;
    end else begin
      wr_pend_q <= addr_ph && claim && (kind == K_CFG) && cmd_wr && bar_sel_hit;
      if (addr_ph) wr_sel_q <= bar_sel_d;
    end
  end

  for (genvar g = 0; g < NBAR; g++) begin : g_bar
    logic bar_wr;
    assign bar_wr = wr_pend_q && (wr_sel_q == 1'(g));
    pci_bar_reg #(
      .ADDR_W   (ADDR_W),
      .WIN_BITS (WIN_BITS),
      .IS_IO    (g == 0)
    ) u_bar (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (bar_wr),
      .data_i (ad_i),
      .be_i   (~cbe_ni[NLANE-1:0]),
      .bar_o  (bar_q[g])
    );
  end

  assign hit_o     = hit_q;
  assign space_o   = sp_q;
  assign write_o   = wr_q;
  assign offset_o  = off_q;
  assign param_o   = param_q;
  assign reg_idx_o = off_q[WIN_BITS-2:0];
  assign bar0_o    = bar_q[0];
  assign bar1_o    = bar_q[1];
endmodule

// File: rtl/pci_addr_decode_chk.sv
module pci_addr_decode_chk #(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                frame_ni,
  input logic [ADDR_W-1:0]   ad_i,
  input logic [3:0]          cbe_ni,
  input logic                idsel_i,
  input logic                hit_o,
  input logic [1:0]          space_o,
  input logic                param_o,
  input logic [WIN_BITS-1:0] offset_o,
  input logic                write_o,
  input logic [ADDR_W-1:0]   bar0_o,
  input logic [ADDR_W-1:0]   bar1_o
);
  assert_bar_fixed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bar0_o[7:0] == 8'h01) && (bar1_o[7:0] == 8'h00));

  assert_cfg_idsel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && space_o == 2'b01) |-> $past(idsel_i));

  assert_cfg_func0_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && space_o == 2'b01) |-> ($past(ad_i[10:8]) == 3'b000 && $past(ad_i[1:0]) == 2'b00));

  assert_param_cfg_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && space_o != 2'b01) |-> !param_o);

  assert_io_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && space_o == 2'b11) |->
      ($past(ad_i[ADDR_W-1:WIN_BITS]) == $past(bar0_o[ADDR_W-1:WIN_BITS]) &&
       offset_o == $past(ad_i[WIN_BITS-1:0])));

  assert_mem_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && space_o == 2'b10) |->
      ($past(ad_i[ADDR_W-1:WIN_BITS]) == $past(bar1_o[ADDR_W-1:WIN_BITS])));

  assert_dir_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (write_o == $past(cbe_ni[0])));

  assert_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o);

  assert_first_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> !$past(frame_ni));

  assert_none_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (space_o == 2'b00));
endmodule

bind pci_addr_decode pci_addr_decode_chk #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .frame_ni (frame_ni),
  .ad_i     (ad_i),
  .cbe_ni   (cbe_ni),
  .idsel_i  (idsel_i),
  .hit_o    (hit_o),
  .space_o  (space_o),
  .param_o  (param_o),
  .offset_o (offset_o),
  .write_o  (write_o),
  .bar0_o   (bar0_o),
  .bar1_o   (bar1_o)
);

// File: tb/pci_addr_decode_test.sv
`timescale 1ns/1ps
module pci_addr_decode_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_ni = 1'b1;
  logic [31:0] ad_i = '0;
  logic [3:0]  cbe_ni = 4'hF;
  logic        idsel_i = 1'b0;
  logic        hit_o, write_o, param_o;
  logic [1:0]  space_o;
  logic [7:0]  offset_o;
  logic [6:0]  reg_idx_o;
  logic [31:0] bar0_o, bar1_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // captured one clock after the address phase
  logic        c_hit, c_wr, c_par;
  logic [1:0]  c_sp;
  logic [7:0]  c_off;
  logic [6:0]  c_idx;

  always #4 clk_i = ~clk_i;

  pci_addr_decode uut (
    .clk_i, .rst_ni, .frame_ni, .ad_i, .cbe_ni, .idsel_i,
    .hit_o, .space_o, .write_o, .offset_o, .param_o, .reg_idx_o,
    .bar0_o, .bar1_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic phase(input logic [3:0] cmd, input logic [31:0] adr, input logic sel,
                       input bit with_data, input logic [31:0] dat, input logic [3:0] be_n);
    @(negedge clk_i);
    frame_ni = 1'b0; ad_i = adr; cbe_ni = cmd; idsel_i = sel;
    @(posedge clk_i); #1;
    c_hit = hit_o; c_sp = space_o; c_wr = write_o;
    c_off = offset_o; c_par = param_o; c_idx = reg_idx_o;
    @(negedge clk_i);
    if (with_data) begin
      ad_i = dat; cbe_ni = be_n; idsel_i = 1'b0;
      @(posedge clk_i); #1;
      @(negedge clk_i);
    end
    frame_ni = 1'b1; idsel_i = 1'b0; cbe_ni = 4'hF; ad_i = '0;
    @(posedge clk_i); #1;
  endtask

  task automatic t_reset;
    chk("R1 hit", 32'(hit_o), 32'd0);
    chk("R1 bar0", bar0_o, 32'h0000_0001);
    chk("R1 bar1", bar1_o, 32'h0000_0000);
    chk("R11 space idle", 32'(space_o), 32'd0);
  endtask

  task automatic t_program_bars;
    phase(4'b1011, 32'h0000_0010, 1'b1, 1'b1, 32'hABCD_12FF, 4'b0000);
    chk("R4 cfg hit", 32'(c_hit), 32'd1);
    chk("R11 cfg space", 32'(c_sp), 32'd1);
    chk("R4 cfg offset", 32'(c_off), 32'h10);
    chk("R4 param low", 32'(c_par), 32'd1);
    chk("R8 cfg write", 32'(c_wr), 32'd1);
    chk("R10 bar0 load", bar0_o, 32'hABCD_1201);
    phase(4'b1011, 32'h0000_0014, 1'b1, 1'b1, 32'h0034_56FF, 4'b0000);
    chk("R10 bar1 load", bar1_o, 32'h0034_5600);
    phase(4'b1011, 32'h0000_0014, 1'b1, 1'b1, 32'hFF11_2233, 4'b0111);
    chk("R10 bar1 lane mask", bar1_o, 32'hFF34_5600);
  endtask

  task automatic t_cfg_gating;
    phase(4'b1011, 32'h0000_0010, 1'b0, 1'b1, 32'h1111_1111, 4'b0000);
    chk("R2 no idsel hit", 32'(c_hit), 32'd0);
    chk("R2 no idsel bar0", bar0_o, 32'hABCD_1201);
    phase(4'b1010, 32'h0000_0204, 1'b1, 1'b0, '0, 4'hF);
    chk("R3 func nonzero", 32'(c_hit), 32'd0);
    phase(4'b1011, 32'h0000_0111, 1'b1, 1'b1, 32'h2222_2222, 4'b0000);
    chk("R3 type1 hit", 32'(c_hit), 32'd0);
    chk("R3 type1 bar0", bar0_o, 32'hABCD_1201);
    phase(4'b1010, 32'h0000_0087, 1'b1, 1'b0, '0, 4'hF);
    chk("R3 ad10 claim", 32'(c_hit), 32'd0);
    phase(4'b1010, 32'h0000_0084, 1'b1, 1'b0, '0, 4'hF);
    chk("R4 upper hit", 32'(c_hit), 32'd1);
    chk("R4 upper offset", 32'(c_off), 32'h84);
    chk("R4 upper param", 32'(c_par), 32'd0);
    chk("R7 cfg idx", 32'(c_idx), 32'h04);
    chk("R8 cfg read", 32'(c_wr), 32'd0);
  endtask

  task automatic t_io;
    phase(4'b0010, 32'hABCD_1283, 1'b0, 1'b0, '0, 4'hF);
    chk("R5 io hit", 32'(c_hit), 32'd1);
    chk("R11 io space", 32'(c_sp), 32'd3);
    chk("R5 io offset", 32'(c_off), 32'h83);
    chk("R7 io fold", 32'(c_idx), 32'h03);
    chk("R4 io param", 32'(c_par), 32'd0);
    phase(4'b0011, 32'hABCD_1203, 1'b0, 1'b0, '0, 4'hF);
    chk("R8 io write", 32'(c_wr), 32'd1);
    chk("R7 io low half", 32'(c_idx), 32'h03);
    phase(4'b0010, 32'hABCD_1303, 1'b0, 1'b0, '0, 4'hF);
    chk("R5 bit8 miss", 32'(c_hit), 32'd0);
    phase(4'b0010, 32'h2BCD_1203, 1'b0, 1'b0, '0, 4'hF);
    chk("R5 bit31 miss", 32'(c_hit), 32'd0);
  endtask

  task automatic t_mem;
    phase(4'b0111, 32'hFF34_5605, 1'b0, 1'b0, '0, 4'hF);
    chk("R6 mem hit", 32'(c_hit), 32'd1);
    chk("R11 mem space", 32'(c_sp), 32'd2);
    chk("R6 mem offset", 32'(c_off), 32'h05);
    chk("R8 mem write", 32'(c_wr), 32'd1);
    phase(4'b0110, 32'hFF34_5685, 1'b0, 1'b0, '0, 4'hF);
    chk("R7 mem fold", 32'(c_idx), 32'h05);
    chk("R8 mem read", 32'(c_wr), 32'd0);
    phase(4'b0110, 32'hABCD_1205, 1'b0, 1'b0, '0, 4'hF);
    chk("R6 mem in io window", 32'(c_hit), 32'd0);
    phase(4'b0010, 32'hFF34_5605, 1'b0, 1'b0, '0, 4'hF);
    chk("R5 io in mem window", 32'(c_hit), 32'd0);
  endtask

  task automatic t_cmds;
    phase(4'b1100, 32'hFF34_5600, 1'b0, 1'b0, '0, 4'hF);
    chk("R8 cmd 1100", 32'(c_hit), 32'd0);
    phase(4'b0000, 32'hABCD_1200, 1'b1, 1'b0, '0, 4'hF);
    chk("R8 cmd 0000", 32'(c_hit), 32'd0);
    phase(4'b1110, 32'hFF34_5600, 1'b0, 1'b0, '0, 4'hF);
    chk("R8 cmd 1110", 32'(c_hit), 32'd0);
    chk("R11 miss space", 32'(c_sp), 32'd0);
  endtask

  task automatic t_held_frame;
    @(negedge clk_i);
    frame_ni = 1'b0; ad_i = 32'hABCD_1210; cbe_ni = 4'b0010;
    @(posedge clk_i); #1;
    chk("R9 first clock hit", 32'(hit_o), 32'd1);
    @(posedge clk_i); #1;
    chk("R9 second clock", 32'(hit_o), 32'd0);
    @(posedge clk_i); #1;
    chk("R9 third clock", 32'(hit_o), 32'd0);
    @(negedge clk_i);
    frame_ni = 1'b1; cbe_ni = 4'hF; ad_i = '0;
    @(posedge clk_i); #1;
    chk("R9 after release", 32'(hit_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_reset();
    t_program_bars();
    t_cfg_gating();
    t_io();
    t_mem();
    t_cmds();
    t_held_frame();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule